// File: doc/BRIEF.md
# Shared-RAM Convolutional Byte Interleaver

This block spreads a stream of 8-bit symbols over time so that a burst of errors on the channel turns into scattered single-symbol errors after the matching deinterleaver. Each accepted byte is routed to the next of `NUM_BRANCHES` branches in turn. Branch `b` holds its bytes back by `b * UNIT` visits to that branch. Branch 0 adds no extra delay.

None of the branch delay lines is built from flip-flop chains. A single RAM of `UNIT * NUM_BRANCHES * (NUM_BRANCHES-1) / 2` bytes holds all of them. Each branch owns a contiguous window of that RAM and keeps its own wrapping pointer. On every access the RAM reads the old byte at the pointer and then overwrites that byte with the new one. This makes every window behave as a shift register of the required length.

A per-branch "filled" flag masks RAM locations that have not been written since reset, so they read as zero. As a result, the RAM itself never needs clearing. The output stream has a one-cycle latency and its own valid strobe.

Top module: `cil_interleaver`

## Requirements
- R1: Each accepted byte (in_valid high) goes to the current branch, and the branch index then advances by one, wrapping from NUM_BRANCHES-1 to 0. Cycles with in_valid low leave the branch index and all pointers unchanged.
- R2: Number the accepted input bytes n = 0, 1, 2, ... from reset, and let b = n mod NUM_BRANCHES. The output byte produced for input n equals input byte n - NUM_BRANCHES*UNIT*b.
- R3: If n < NUM_BRANCHES*UNIT*b, the output byte for input n is zero.
- R4: Bytes on branch 0 appear at the output unchanged, with the same latency as the RAM branches.
- R5: out_valid is high exactly one clock after each cycle in which a byte was accepted, and low otherwise.
- R6: Synchronous active-high reset returns the branch index to 0 and clears all pointers and filled flags. After reset the stream follows R2 and R3 afresh, as if the RAM were empty, and out_valid is low during reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input byte present this cycle |
| in_data | input | 8 | Input byte |
| out_valid | output | 1 | Interleaved byte present this cycle |
| out_data | output | 8 | Interleaved byte |

## Verification
The bench drives a small configuration with five branches and a unit of two. It keeps an arithmetic model that indexes the accepted bytes, so every output is predicted from its branch number alone. Windows that are still filling must yield zero; a design that dropped the filled mask would leak uninitialised or stale RAM bytes there. The bench inserts idle cycles between bytes, which exposes a commutator or pointer that wrongly advances on invalid cycles, because every later byte then lands on the wrong delay. A reset in the middle of the stream, with old data left in the RAM, catches pointers or flags that survive reset: the design would then replay bytes from before the reset instead of zeros.

// File: rtl/cil_pkg.sv
package cil_pkg;

    localparam int SYM_W = 8;

    typedef logic [SYM_W-1:0] sym_t;

    // registered view of one access, aligned with the RAM read data
    typedef struct packed {
        logic valid;
        logic bypass;
        logic filled;
        sym_t direct;
    } stage_t;

    // first RAM word of branch b's window
    function automatic int window_base(input int b, input int unit);
        return unit * b * (b - 1) / 2;
    endfunction

endpackage

// File: rtl/cil_commutator.sv
module cil_commutator #(
    parameter int NB = 52,
    localparam int BW = (NB > 1) ? $clog2(NB) : 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          adv,
    output logic [BW-1:0] sel
);
    always_ff @(posedge clk) begin
        if (rst)
            sel <= '0;
        else if (adv)
            sel <= (sel == BW'(NB - 1)) ? '0 : sel + 1'b1;
    end
endmodule

// File: rtl/cil_pointer_bank.sv
module cil_pointer_bank #(
    parameter int NB   = 52,
    parameter int UNIT = 4,
    localparam int BW  = (NB > 1) ? $clog2(NB) : 1,
    localparam int PW  = (UNIT * (NB - 1) > 1) ? $clog2(UNIT * (NB - 1)) : 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          adv,
    input  logic [BW-1:0] sel,
    output logic [PW-1:0] ptr,
    output logic          filled
);
    logic [PW-1:0] ptr_arr  [NB];
    logic          fill_arr [NB];

    for (genvar b = 0; b < NB; b++) begin : g_br
        if (b == 0) begin : g_pass
            assign ptr_arr[b]  = '0;
            assign fill_arr[b] = 1'b0;
        end else begin : g_win
            logic [PW-1:0] p_q;
            logic          f_q;
            always_ff @(posedge clk) begin
                if (rst) begin
                    p_q <= '0;
                    f_q <= 1'b0;
                end else if (adv && sel == BW'(b)) begin
                    if (p_q == PW'(UNIT * b - 1)) begin
                        p_q <= '0;
                        f_q <= 1'b1;
                    end else begin
                        p_q <= p_q + 1'b1;
                    end
                end
            end
            assign ptr_arr[b]  = p_q;
            assign fill_arr[b] = f_q;
        end
    end

    assign ptr    = ptr_arr[sel];
    assign filled = fill_arr[sel];
endmodule

// File: rtl/cil_store.sv
module cil_store #(
    parameter int DEPTH = 5304,
    localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic              clk,
    input  logic              en,
    input  logic [AW-1:0]     addr,
    input  cil_pkg::sym_t     wdata,
    output cil_pkg::sym_t     rdata
);
    cil_pkg::sym_t mem [DEPTH];

    // old contents leave on the read port, new byte takes their place
    always_ff @(posedge clk) begin
        if (en) begin
            rdata     <= mem[addr];
            mem[addr] <= wdata;
        end
    end
endmodule

// File: rtl/cil_interleaver.sv
module cil_interleaver #(
    parameter int NUM_BRANCHES = 52,
    parameter int UNIT         = 4
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       in_valid,
    input  logic [7:0] in_data,
    output logic       out_valid,
    output logic [7:0] out_data
);
    import cil_pkg::*;

    localparam int DEPTH = UNIT * NUM_BRANCHES * (NUM_BRANCHES - 1) / 2;
    localparam int AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int BW    = (NUM_BRANCHES > 1) ? $clog2(NUM_BRANCHES) : 1;
    localparam int PW    = (UNIT * (NUM_BRANCHES - 1) > 1) ? $clog2(UNIT * (NUM_BRANCHES - 1)) : 1;

    logic [BW-1:0] br_sel;
    logic [PW-1:0] br_ptr;
    logic          br_filled;
    logic [AW-1:0] ram_addr;
    logic          ram_en;
    sym_t          ram_rd;
    stage_t        stg_q;

    cil_commutator #(.NB(NUM_BRANCHES)) u_comm (
        .clk (clk),
        .rst (rst),
        .adv (in_valid),
        .sel (br_sel)
    );

    cil_pointer_bank #(.NB(NUM_BRANCHES), .UNIT(UNIT)) u_ptrs (
        .clk    (clk),
        .rst    (rst),
        .adv    (in_valid),
        .sel    (br_sel),
        .ptr    (br_ptr),
        .filled (br_filled)
    );

    always_comb begin
        ram_addr = AW'(window_base(int'(br_sel), UNIT)) + AW'(br_ptr);
        ram_en   = in_valid && !rst && (br_sel != '0);
    end

    cil_store #(.DEPTH(DEPTH)) u_ram (
        .clk   (clk),
        .en    (ram_en),
        .addr  (ram_addr),
        .wdata (in_data),
        .rdata (ram_rd)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            stg_q <= '0;
        end else begin
            stg_q.valid  <= in_valid;
            stg_q.bypass <= (br_sel == '0);
            stg_q.filled <= br_filled;
            stg_q.direct <= in_data;
        end
    end

    assign out_valid = stg_q.valid;
    assign out_data  = stg_q.bypass ? stg_q.direct
                     : (stg_q.filled ? ram_rd : '0);
endmodule

// File: rtl/cil_interleaver_chk.sv
module cil_interleaver_chk #(
    parameter int NB  = 52,
    localparam int BW = (NB > 1) ? $clog2(NB) : 1
) (
    input logic          clk,
    input logic          rst,
    input logic          in_valid,
    input logic [7:0]    in_data,
    input logic          out_valid,
    input logic [7:0]    out_data,
    input logic [BW-1:0] sel
);
    p_sel_range_r1: assert property (@(posedge clk) disable iff (rst)
        sel < BW'(NB));

    p_commutator_step_r1: assert property (@(posedge clk) disable iff (rst)
        (in_valid && sel != BW'(NB - 1)) |=> sel == $past(sel) + 1'b1);

    p_commutator_wrap_r1: assert property (@(posedge clk) disable iff (rst)
        (in_valid && sel == BW'(NB - 1)) |=> sel == '0);

    p_idle_hold_r1: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> $stable(sel));

    p_passthrough_r4: assert property (@(posedge clk) disable iff (rst)
        (in_valid && sel == '0) |=> out_data == $past(in_data));

    p_valid_follows_r5: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);

    p_valid_idle_r5: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid);

    p_reset_home_r6: assert property (@(posedge clk)
        rst |=> (sel == '0 && !out_valid));
endmodule

bind cil_interleaver cil_interleaver_chk #(.NB(NUM_BRANCHES)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .in_data   (in_data),
    .out_valid (out_valid),
    .out_data  (out_data),
    .sel       (br_sel)
);

// File: tb/cil_interleaver_test.sv
`timescale 1ns/1ps
module cil_interleaver_test;
    localparam int NB   = 5;
    localparam int UNIT = 2;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       in_valid = 1'b0;
    logic [7:0] in_data = '0;
    logic       out_valid;
    logic [7:0] out_data;

    always #10 clk = ~clk;

    cil_interleaver #(.NUM_BRANCHES(NB), .UNIT(UNIT)) uut (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (in_valid),
        .in_data   (in_data),
        .out_valid (out_valid),
        .out_data  (out_data)
    );

    int         vectors = 0;
    int         errs    = 0;
    logic [7:0] hist [1024];
    int         n = 0;
    logic       pend_v = 1'b0;
    logic [7:0] pend_d = '0;
    string      pend_tag = "";
    string      phase_tag = "";
    logic [7:0] lfsr = 8'hA5;

    task automatic step(input bit v, input logic [7:0] d);
        int b, dly;
        @(negedge clk);
        vectors++;
        if (out_valid !== pend_v) begin
            errs++;
            $display("FAIL R5: out_valid=%0b expected %0b", out_valid, pend_v);
        end else if (pend_v && out_data !== pend_d) begin
            errs++;
            $display("FAIL %s: out_data=%02h expected %02h (byte %0d)", pend_tag, out_data, pend_d, n - 1);
        end
        pend_v = v;
        if (v) begin
            hist[n] = d;
            b   = n % NB;
            dly = NB * UNIT * b;
            pend_d = (n >= dly) ? hist[n - dly] : 8'h00;
            if (phase_tag != "")  pend_tag = phase_tag;
            else if (b == 0)      pend_tag = "R4";
            else if (n < dly)     pend_tag = "R3";
            else                  pend_tag = "R2";
            n++;
        end
        in_valid = v;
        in_data  = d;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        in_valid = 1'b0;
        repeat (3) @(negedge clk);
        vectors++;
        if (out_valid !== 1'b0) begin
            errs++;
            $display("FAIL R6: out_valid=%0b expected 0 during reset", out_valid);
        end
        rst = 1'b0;
        n = 0;
        pend_v = 1'b0;
    endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errs);
        $finish;
    endtask

    initial begin
        #(20 * 5000);
        errs++;
        $display("FAIL watchdog: run did not complete, expected completion");
        finish_run();
    end

    initial begin
        do_reset();
        // R2/R3/R4: back-to-back bytes
        phase_tag = "";
        for (int k = 0; k < 120; k++) step(1'b1, 8'(k * 37 + 11));
        // R1: idle gaps must not move commutator or pointers
        phase_tag = "R1";
        for (int k = 0; k < 200; k++) begin
            lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
            step(lfsr[0] | lfsr[2], lfsr ^ 8'h3C);
        end
        step(1'b0, 8'h00);
        // R6: reset with stale RAM contents, stream restarts empty
        do_reset();
        phase_tag = "R6";
        for (int k = 0; k < 90; k++) step(1'b1, 8'(k * 13 + 200));
        step(1'b0, 8'h00);
        step(1'b0, 8'h00);
        finish_run();
    end
endmodule